// File: doc/BRIEF.md
# Multi-Mode Packed Nibble Adder

This block adds two 32-bit words in one of three ways, chosen per operation by a 2-bit mode input. In binary mode the words are ordinary unsigned integers and the carry runs through all 32 bits. In decimal mode each word holds eight packed BCD digits. Every digit sum above nine is corrected, and a decimal carry moves into the next digit. In lane mode each word holds eight independent 4-bit unsigned values. No carry crosses a lane boundary, and a lane whose true sum does not fit is clamped to its maximum.

Operands are offered together with an input valid strobe. The result, a decimal carry-out and a per-lane clamp mask are registered and appear one clock later with an output valid strobe. Nibble i of a word always occupies bits 4i+3 down to 4i, so the least significant digit or lane is in bits 3:0 and the most significant is in bits 31:28.

Top module: `nibble_mode_adder`

## Requirements
- R1: With mode 2'b00 the result is (op_a + op_b) mod 2^32, for example 0x04d7 + 0x162e = 0x1b05.
- R2: With mode 2'b01 the operands are added as eight-digit decimal numbers, with a digit sum above 9 corrected by adding 6, for example 0x1239 + 0x5678 = 0x6917.
- R3: In mode 2'b01, dec_carry is the carry out of digit 7 (bits 31:28), for example 0x99999999 + 0x00000001 gives result 0 and dec_carry 1. In every other mode dec_carry is 0.
- R4: With mode 2'b10 no carry passes between the eight 4-bit lanes, for example 0x1239 + 0x5678 = 0x68af.
- R5: In mode 2'b10 a lane whose true sum exceeds 15 yields 15, for example 12 + 8 gives 15.
- R6: sat_mask bit i is 1 exactly when lane i (bits 4i+3:4i) was clamped in mode 2'b10. sat_mask is all zero in other modes.
- R7: out_valid equals in_valid delayed by one clock, and the outputs of an operation appear in that same cycle.
- R8: After a cycle with in_valid low, result, dec_carry and sat_mask keep their previous values.
- R9: While rst_n is low, out_valid, result, dec_carry and sat_mask are all 0.
- R10: Digits above 9 in mode 2'b01 give an unspecified result, but out_valid still follows R7 and the next operation is correct.
- R11: Mode 2'b11 behaves exactly like mode 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 2 | 00 binary, 01 decimal, 10 saturating lanes, 11 binary |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | Registered outputs hold a new result |
| result | output | 32 | Registered sum |
| dec_carry | output | 1 | Decimal carry out of the top digit |
| sat_mask | output | 8 | Per-lane clamp flags |

## Verification
Two functions of this block can act in the same cycle. In decimal mode, a digit correction can produce a carry that ripples across several digits and leaves the top digit, so dec_carry must rise in the cycle that the corrected digits land. In lane mode, clamping in one lane can coincide with a lane right next to it that sits at exactly 15 without overflowing, so the mask must separate a clamp from a true 15. Both cases are provoked with directed words (all nines plus one, and lanes at F+0 beside C+8) and with random mixed-mode operations. Every cycle is compared against a bench model that uses integer decimal arithmetic and per-lane minimum arithmetic.

// File: rtl/nma_pkg.sv
package nma_pkg;
   typedef enum logic [1:0] {
      NMA_BIN  = 2'b00,
      NMA_DEC  = 2'b01,
      NMA_LANE = 2'b10,
      NMA_BIN2 = 2'b11
   } nma_mode_e;
endpackage

// File: rtl/nma_nibble_cell.sv
module nma_nibble_cell
   import nma_pkg::*;
#(
   parameter int NIB_W = 4
) (
   input  logic [1:0]       mode,
   input  logic [NIB_W-1:0] a,
   input  logic [NIB_W-1:0] b,
   input  logic             cin,
   output logic [NIB_W-1:0] sum,
   output logic             cout,
   output logic             clamp
);
   localparam int RAW_W = NIB_W + 1;
   localparam logic [RAW_W-1:0] DEC_LIMIT = RAW_W'(9);
   localparam logic [RAW_W-1:0] DEC_CORR  = RAW_W'((1 << NIB_W) - 10);

   logic [RAW_W-1:0] raw;
   logic [RAW_W-1:0] corrected;

   always_comb begin
      raw       = {1'b0, a} + {1'b0, b} + {{NIB_W{1'b0}}, cin};
      corrected = raw + DEC_CORR;
   end

   always_comb begin
      sum   = raw[NIB_W-1:0];
      cout  = raw[NIB_W];
      clamp = 1'b0;
      unique case (mode)
         NMA_DEC: begin
            if (raw > DEC_LIMIT) begin
               sum  = corrected[NIB_W-1:0];
               cout = 1'b1;
            end else begin
               cout = 1'b0;
            end
         end
         NMA_LANE: begin
            clamp = raw[NIB_W];
            cout  = 1'b0;
            if (raw[NIB_W]) sum = '1;
         end
         default: begin
         end
      endcase
   end
endmodule

// File: rtl/nma_datapath.sv
module nma_datapath
   import nma_pkg::*;
#(
   parameter int LANES = 8,
   parameter int NIB_W = 4,
   localparam int WORD_W = LANES * NIB_W
) (
   input  logic [1:0]        mode,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   output logic [WORD_W-1:0] sum,
   output logic              dec_carry,
   output logic [LANES-1:0]  clamp
);
   logic [LANES:0] chain;

   assign chain[0] = 1'b0;

   for (genvar gi = 0; gi < LANES; gi++) begin : g_cell
      nma_nibble_cell #(.NIB_W(NIB_W)) u_cell (
         .mode  (mode),
         .a     (op_a[gi*NIB_W +: NIB_W]),
         .b     (op_b[gi*NIB_W +: NIB_W]),
         .cin   (chain[gi]),
         .sum   (sum[gi*NIB_W +: NIB_W]),
         .cout  (chain[gi+1]),
         .clamp (clamp[gi])
      );
   end

   assign dec_carry = (mode == NMA_DEC) ? chain[LANES] : 1'b0;
endmodule

// File: rtl/nma_out_stage.sv
module nma_out_stage #(
   parameter int LANES = 8,
   parameter int NIB_W = 4,
   localparam int WORD_W = LANES * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] d_sum,
   input  logic              d_carry,
   input  logic [LANES-1:0]  d_clamp,
   output logic              q_valid,
   output logic [WORD_W-1:0] q_sum,
   output logic              q_carry,
   output logic [LANES-1:0]  q_clamp
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_sum   <= '0;
         q_carry <= 1'b0;
         q_clamp <= '0;
      end else begin
         q_valid <= load;
         if (load) begin
            q_sum   <= d_sum;
            q_carry <= d_carry;
            q_clamp <= d_clamp;
         end
      end
   end
endmodule

// File: rtl/nibble_mode_adder.sv
module nibble_mode_adder #(
   parameter int LANES = 8,
   parameter int NIB_W = 4,
   localparam int WORD_W = LANES * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        mode,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   output logic              out_valid,
   output logic [WORD_W-1:0] result,
   output logic              dec_carry,
   output logic [LANES-1:0]  sat_mask
);
   if (NIB_W != 4) begin : g_bad_nib
      $error("nibble_mode_adder: decimal digits need NIB_W of 4");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("nibble_mode_adder: LANES must be at least 1");
   end

   logic [WORD_W-1:0] c_sum;
   logic              c_carry;
   logic [LANES-1:0]  c_clamp;

   nma_datapath #(.LANES(LANES), .NIB_W(NIB_W)) u_dp (
      .mode      (mode),
      .op_a      (op_a),
      .op_b      (op_b),
      .sum       (c_sum),
      .dec_carry (c_carry),
      .clamp     (c_clamp)
   );

   nma_out_stage #(.LANES(LANES), .NIB_W(NIB_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (in_valid),
      .d_sum   (c_sum),
      .d_carry (c_carry),
      .d_clamp (c_clamp),
      .q_valid (out_valid),
      .q_sum   (result),
      .q_carry (dec_carry),
      .q_clamp (sat_mask)
   );
endmodule

// File: rtl/nma_checker.sv
module nma_checker #(
   parameter int LANES = 8,
   parameter int NIB_W = 4,
   localparam int WORD_W = LANES * NIB_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        mode,
   input logic [WORD_W-1:0] op_a,
   input logic [WORD_W-1:0] op_b,
   input logic              out_valid,
   input logic [WORD_W-1:0] result,
   input logic              dec_carry,
   input logic [LANES-1:0]  sat_mask
);
   logic [WORD_W-1:0] mask_bits;
   for (genvar gi = 0; gi < LANES; gi++) begin : g_exp
      assign mask_bits[gi*NIB_W +: NIB_W] = {NIB_W{sat_mask[gi]}};
   end

   always_comb begin
      if (!rst_n) begin
         AST_RESET_CLEAR: assert (!out_valid && result == '0 && !dec_carry && sat_mask == '0); // R9
      end
   end

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(in_valid))); // R7

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(dec_carry) && $stable(sat_mask))); // R8

   AST_BIN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (mode == 2'b00 || mode == 2'b11)) |=> (result == WORD_W'($past(op_a) + $past(op_b)))); // R1

   AST_NO_DEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode != 2'b01) |=> !dec_carry); // R3

   AST_MASK_LANE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode != 2'b10) |=> (sat_mask == '0)); // R6

   AST_CLAMP_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 2'b10) |=> ((result & mask_bits) == mask_bits)); // R5
endmodule

bind nibble_mode_adder nma_checker #(.LANES(LANES), .NIB_W(NIB_W)) u_nma_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .mode      (mode),
   .op_a      (op_a),
   .op_b      (op_b),
   .out_valid (out_valid),
   .result    (result),
   .dec_carry (dec_carry),
   .sat_mask  (sat_mask)
);

// File: tb/nibble_mode_adder_tb.sv
module nibble_mode_adder_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic        out_valid;
   logic [31:0] result;
   logic        dec_carry;
   logic [7:0]  sat_mask;

   int checks = 0;
   int errors = 0;

   logic        exp_valid = 1'b0;
   logic [31:0] exp_res = '0;
   logic        exp_carry = 1'b0;
   logic [7:0]  exp_mask = '0;
   bit          exp_res_known = 1'b1;
   string       cur_tag = "R9";

   always #(CLK_PERIOD/2) clk = ~clk;

   nibble_mode_adder dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result),
      .dec_carry(dec_carry), .sat_mask(sat_mask)
   );

   function automatic longint dec_val(input logic [31:0] w);
      longint v = 0;
      for (int i = 7; i >= 0; i--) v = v * 10 + longint'(w[i*4 +: 4]);
      return v;
   endfunction

   task automatic check(input string tag, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare();
      check("R7", "out_valid", longint'(out_valid), longint'(exp_valid));
      if (exp_res_known) check(cur_tag, "result", longint'(result), longint'(exp_res));
      check(cur_tag, "dec_carry", longint'(dec_carry), longint'(exp_carry));
      check(cur_tag, "sat_mask", longint'(sat_mask), longint'(exp_mask));
   endtask

   task automatic cycle(input logic v, input logic [1:0] m, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
      @(negedge clk);
      compare();
      in_valid = v; mode = m; op_a = a; op_b = b;
      exp_valid = v;
      if (!v) begin
         cur_tag = (tag == "") ? "R8" : tag;
      end else begin
         cur_tag = tag;
         exp_res_known = 1'b1;
         exp_carry = 1'b0;
         exp_mask = '0;
         if (m == 2'b01) begin
            bit ok = 1'b1;
            for (int i = 0; i < 8; i++) if (a[i*4 +: 4] > 9 || b[i*4 +: 4] > 9) ok = 1'b0;
            if (!ok) begin
               exp_res_known = 1'b0;
               exp_carry = 1'bx;
            end else begin
               longint s = dec_val(a) + dec_val(b);
               exp_carry = (s >= 100000000);
               s = s % 100000000;
               for (int i = 0; i < 8; i++) begin
                  exp_res[i*4 +: 4] = 4'(s % 10);
                  s = s / 10;
               end
            end
         end else if (m == 2'b10) begin
            for (int i = 0; i < 8; i++) begin
               int s = int'(a[i*4 +: 4]) + int'(b[i*4 +: 4]);
               exp_mask[i] = (s > 15);
               exp_res[i*4 +: 4] = (s > 15) ? 4'hf : 4'(s);
            end
         end else begin
            exp_res = a + b;
         end
      end
   endtask

   task automatic compare_any_carry();
      // used after an operation whose carry is unspecified (R10)
      check("R7", "out_valid", longint'(out_valid), longint'(exp_valid));
      check("R10", "sat_mask", longint'(sat_mask), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R9: reset state
      repeat (3) begin
         @(negedge clk);
         compare();
      end
      rst_n = 1'b1;
      cycle(1, 2'b00, 32'h0000_04d7, 32'h0000_162e, "R1");
      cycle(1, 2'b01, 32'h0000_1239, 32'h0000_5678, "R2");
      cycle(1, 2'b01, 32'h9999_9999, 32'h0000_0001, "R3");
      cycle(1, 2'b10, 32'h0000_1239, 32'h0000_5678, "R4");
      cycle(1, 2'b10, 32'h0000_000c, 32'h0000_0008, "R5");
      cycle(1, 2'b10, 32'hf0c0_f0c0, 32'h0080_0080, "R6");
      cycle(1, 2'b10, 32'hffff_ffff, 32'h1111_1111, "R6");
      cycle(1, 2'b00, 32'hffff_ffff, 32'h0000_0001, "R1");
      cycle(0, 2'b01, 32'h9999_9999, 32'h9999_9999, "R8");
      cycle(0, 2'b10, 32'hffff_ffff, 32'hffff_ffff, "R8");
      cycle(1, 2'b11, 32'h0000_0fff, 32'h0000_0001, "R11");
      cycle(1, 2'b01, 32'h5555_5555, 32'h4444_4445, "R3");
      cycle(1, 2'b01, 32'hfafa_fafa, 32'hffff_ffff, "R10");
      @(negedge clk);
      compare_any_carry();
      exp_res_known = 1'b1;
      in_valid = 1'b1; mode = 2'b01; op_a = 32'h0000_0099; op_b = 32'h0000_0001;
      exp_valid = 1'b1; exp_res = 32'h0000_0100; exp_carry = 1'b0; exp_mask = '0;
      cur_tag = "R10";
      for (int k = 0; k < 400; k++) begin
         logic [1:0]  m = 2'($urandom_range(0, 3));
         logic [31:0] a = $urandom;
         logic [31:0] b = $urandom;
         logic        v = ($urandom_range(0, 3) != 0);
         if (m == 2'b01) begin
            for (int i = 0; i < 8; i++) begin
               a[i*4 +: 4] = 4'($urandom_range(0, 9));
               b[i*4 +: 4] = 4'($urandom_range(0, 9));
            end
         end
         cycle(v, m, a, b, (m == 2'b01) ? "R2" : (m == 2'b10) ? "R5" : "R1");
      end
      cycle(0, 2'b00, '0, '0, "R8");
      @(negedge clk);
      compare();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule